// File: doc/BRIEF.md
# MONITOR Channel Master Handshake Controller

This block carries a byte message across the MONITOR byte of a single IOM-2 channel in the master role. Once per 8 kHz frame, marked by a one-cycle frame strobe, it drives the outgoing MONITOR byte and its two handshake bits and samples the bits and byte that the far end drives. The transmit bit (MX) and the receive bit (MR) are active low. Both follow host control inputs; the block does not sequence them itself. The block watches the combined bus levels and turns the handshake into host events. Byte acknowledge, message end, far-end abort and byte received each give a one-cycle pulse and set a sticky flag.

To send, the host loads the first byte and raises its MX request. It waits for the acknowledge event. For each later byte it loads the byte, drops the MX request for one frame and raises it again. It ends the message by leaving MX released. The channel-active output stays high until two consecutive frames show both bits inactive. The host must not start a new message before that. When receiving, each far-end MX edge from inactive to active captures a byte. If the low nibble of the first byte of a message equals 1, the message is flagged as a programming sequence.

Top module: `mon_hs_ctrl`

## Requirements
- R1: After reset, the MX and MR outputs are 1 (inactive) and the outgoing byte is 8'hFF. Channel-active, the programming flag, the received byte, all event pulses and all sticky flags are 0.
- R2: On each frame strobe, the MX output becomes the inverse of the host MX request and the MR output becomes the inverse of the host MR request. The outgoing byte takes the last byte the host wrote. Between strobes these outputs hold.
- R3: Channel-active goes to 1 at a strobe when the host requests MX or MR, or when the frame just ended had MX or MR active on the bus (own level AND far-end level). It returns to 0 only when the message end is detected.
- R4: Message end is detected at the strobe that closes the second consecutive frame in which both MX and MR were inactive on the bus while the channel was active. It gives a one-cycle end pulse. A single inactive frame gives no end.
- R5: The acknowledge pulse is raised for a frame that carried a newly marked byte (own MX active after being inactive) in which the far-end MR was active. Further frames with MR still active raise no more acknowledges.
- R6: The abort pulse is raised when the far-end MR goes from active to inactive across a frame in which own MX was active and the current byte was already acknowledged. It is not raised when own MX was inactive, nor during a newly marked byte. It never coincides with an acknowledge.
- R7: A far-end MX change from inactive to active captures the sampled MONITOR byte into the received-byte output and raises the received pulse. A far-end MX that stays active captures nothing.
- R8: The programming flag takes the value (low nibble == 4'h1) of the first byte captured after reset or after a message end. Later bytes of the same message leave it unchanged.
- R9: Sticky flag bits are [0] acknowledge, [1] end, [2] abort and [3] received. Each bit is set in the cycle after its pulse and cleared by a one-cycle host read strobe.
- R10: Every event pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_tick | input | 1 | One-cycle strobe at each frame boundary |
| host_tx_data | input | 8 | Byte to send |
| host_tx_wr | input | 1 | Write strobe for host_tx_data |
| host_mx_act | input | 1 | Host request: drive MX active |
| host_mr_act | input | 1 | Host request: drive MR active |
| host_sts_rd | input | 1 | Read strobe that clears the sticky flags |
| line_rx_byte | input | 8 | MONITOR byte sampled from the far end |
| line_mx_in | input | 1 | Far-end MX level (active low) |
| line_mr_in | input | 1 | Far-end MR level (active low) |
| line_tx_byte | output | 8 | MONITOR byte driven for the current frame |
| line_mx_out | output | 1 | Own MX level (active low) |
| line_mr_out | output | 1 | Own MR level (active low) |
| chan_active | output | 1 | Transfer in progress |
| rx_byte | output | 8 | Last captured byte |
| prog_seq | output | 1 | First byte of the message had low nibble 1 |
| ev_ack | output | 1 | Acknowledge pulse |
| ev_end | output | 1 | Message-end pulse |
| ev_abort | output | 1 | Far-end abort pulse |
| ev_rx | output | 1 | Byte-received pulse |
| sts_flags | output | 4 | Sticky flags {rx, abort, end, ack} |

## Verification
The bench separates the one-frame MX gap that marks a new byte from a real end. An idle detector that counts one frame would end every message after its first byte. It replays the receiver dropping MR in the same frame that a new byte appears: a design without the pending-byte term would report that as an abort. The bench then holds MR active over several frames to show that a level-sensitive acknowledge would fire every frame. Finally, it sends a second message whose first byte has a different low nibble, which catches a programming flag that is never re-armed after a message end.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;

  localparam int EV_ACK   = 0;
  localparam int EV_END   = 1;
  localparam int EV_ABORT = 2;
  localparam int EV_RX    = 3;
  localparam int EV_COUNT = 4;

  // handshake bits are active low
  function automatic logic lvl_active(input logic lvl_n);
    return !lvl_n;
  endfunction

  function automatic logic became_active(input logic prev_n, input logic cur_n);
    return prev_n && !cur_n;
  endfunction

  function automatic logic became_quiet(input logic prev_n, input logic cur_n);
    return !prev_n && cur_n;
  endfunction

  function automatic logic nibble_matches(input logic [3:0] nib, input logic [3:0] code);
    return nib == code;
  endfunction

endpackage

// File: rtl/mon_tx_side.sv
module mon_tx_side
  import mon_hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] host_data,
  input  logic              host_wr,
  input  logic              host_mx_act,
  input  logic              host_mr_act,
  input  logic              far_mr_n,
  output logic [DATA_W-1:0] tx_byte,
  output logic              mx_n,
  output logic              mr_n,
  output logic              ack_hit,
  output logic              abort_hit
);

  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  logic [DATA_W-1:0] tx_buf;
  logic              far_mr_q;
  logic              pending;
  logic              mark_new;

  assign mark_new  = tick && mx_n && host_mx_act;
  assign ack_hit   = tick && pending && lvl_active(mx_n) && lvl_active(far_mr_n);
  assign abort_hit = tick && became_quiet(far_mr_q, far_mr_n) && lvl_active(mx_n) && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= IDLE_BYTE;
    end else if (host_wr) begin
      tx_buf <= host_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte  <= IDLE_BYTE;
      mx_n     <= 1'b1;
      mr_n     <= 1'b1;
      far_mr_q <= 1'b1;
      pending  <= 1'b0;
    end else if (tick) begin
      tx_byte  <= tx_buf;
      mx_n     <= !host_mx_act;
      mr_n     <= !host_mr_act;
      far_mr_q <= far_mr_n;
      pending  <= host_mx_act && (mark_new || (pending && !ack_hit));
    end
  end

  assert_drive_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (mx_n == !$past(host_mx_act)) && (mr_n == !$past(host_mr_act)));

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mx_n) && $stable(mr_n) && $stable(tx_byte));

  assert_ack_abort_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_hit && abort_hit));

endmodule

// File: rtl/mon_rx_side.sv
module mon_rx_side
  import mon_hs_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [3:0]  PROG_CODE = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              far_mx_n,
  input  logic [DATA_W-1:0] line_byte,
  input  logic              msg_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              prog_seq,
  output logic              rx_hit
);

  logic far_mx_q;
  logic first_pending;

  assign rx_hit = tick && became_active(far_mx_q, far_mx_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_mx_q      <= 1'b1;
      rx_byte       <= '0;
      prog_seq      <= 1'b0;
      first_pending <= 1'b1;
    end else begin
      if (tick) far_mx_q <= far_mx_n;
      if (rx_hit) begin
        rx_byte       <= line_byte;
        first_pending <= 1'b0;
        if (first_pending) prog_seq <= nibble_matches(line_byte[3:0], PROG_CODE);
      end else if (msg_done) begin
        first_pending <= 1'b1;
      end
    end
  end

  assert_prog_first_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && !first_pending) |=> $stable(prog_seq));

  assert_capture_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |=> rx_byte == $past(line_byte));

endmodule

// File: rtl/mon_idle_track.sv
module mon_idle_track #(
  parameter int IDLE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bus_mx_n,
  input  logic bus_mr_n,
  input  logic start_req,
  output logic busy,
  output logic end_hit
);

  localparam int CNT_W = $clog2(IDLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_FRAMES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_FRAMES - 1);

  logic [CNT_W-1:0] quiet_cnt;
  logic             quiet;

  assign quiet   = bus_mx_n && bus_mr_n;
  assign end_hit = tick && busy && quiet && (quiet_cnt >= CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= CNT_MAX;
      busy      <= 1'b0;
    end else if (tick) begin
      if (!quiet)                  quiet_cnt <= '0;
      else if (quiet_cnt != CNT_MAX) quiet_cnt <= quiet_cnt + 1'b1;
      if (!quiet || start_req)     busy <= 1'b1;
      else if (end_hit)            busy <= 1'b0;
    end
  end

  assert_busy_clears_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(end_hit));

  assert_no_end_when_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !quiet) |-> !end_hit);

endmodule

// File: rtl/mon_evt_flags.sv
module mon_evt_flags #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] hits,
  input  logic               clr,
  output logic [NUM_EVT-1:0] pulses,
  output logic [NUM_EVT-1:0] sticky
);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulses[i] <= 1'b0;
        sticky[i] <= 1'b0;
      end else begin
        pulses[i] <= hits[i];
        sticky[i] <= pulses[i] || (sticky[i] && !clr);
      end
    end

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pulses[i] |=> !pulses[i]);

    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulses[i] |=> sticky[i]);
  end

endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl
  import mon_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_tick,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_tx_wr,
  input  logic              host_mx_act,
  input  logic              host_mr_act,
  input  logic              host_sts_rd,
  input  logic [DATA_W-1:0] line_rx_byte,
  input  logic              line_mx_in,
  input  logic              line_mr_in,
  output logic [DATA_W-1:0] line_tx_byte,
  output logic              line_mx_out,
  output logic              line_mr_out,
  output logic              chan_active,
  output logic [DATA_W-1:0] rx_byte,
  output logic              prog_seq,
  output logic              ev_ack,
  output logic              ev_end,
  output logic              ev_abort,
  output logic              ev_rx,
  output logic [EV_COUNT-1:0] sts_flags
);

  // named internal events
  logic                ack_hit;
  logic                abort_hit;
  logic                rx_hit;
  logic                end_hit;
  logic                bus_mx_n;
  logic                bus_mr_n;
  logic [EV_COUNT-1:0] hits;
  logic [EV_COUNT-1:0] pulses;

  mon_tx_side #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (frm_tick),
    .host_data  (host_tx_data),
    .host_wr    (host_tx_wr),
    .host_mx_act(host_mx_act),
    .host_mr_act(host_mr_act),
    .far_mr_n   (line_mr_in),
    .tx_byte    (line_tx_byte),
    .mx_n       (line_mx_out),
    .mr_n       (line_mr_out),
    .ack_hit    (ack_hit),
    .abort_hit  (abort_hit)
  );

  mon_rx_side #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frm_tick),
    .far_mx_n (line_mx_in),
    .line_byte(line_rx_byte),
    .msg_done (end_hit),
    .rx_byte  (rx_byte),
    .prog_seq (prog_seq),
    .rx_hit   (rx_hit)
  );

  // open-drain bus: active (0) if either side drives it
  assign bus_mx_n = line_mx_out && line_mx_in;
  assign bus_mr_n = line_mr_out && line_mr_in;

  mon_idle_track #(.IDLE_FRAMES(IDLE_FRAMES)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frm_tick),
    .bus_mx_n (bus_mx_n),
    .bus_mr_n (bus_mr_n),
    .start_req(host_mx_act || host_mr_act),
    .busy     (chan_active),
    .end_hit  (end_hit)
  );

  always_comb begin
    hits           = '0;
    hits[EV_ACK]   = ack_hit;
    hits[EV_END]   = end_hit;
    hits[EV_ABORT] = abort_hit;
    hits[EV_RX]    = rx_hit;
  end

  mon_evt_flags #(.NUM_EVT(EV_COUNT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hits  (hits),
    .clr   (host_sts_rd),
    .pulses(pulses),
    .sticky(sts_flags)
  );

  assign ev_ack   = pulses[EV_ACK];
  assign ev_end   = pulses[EV_END];
  assign ev_abort = pulses[EV_ABORT];
  assign ev_rx    = pulses[EV_RX];

  assert_end_drops_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_active) |-> ev_end);

endmodule

// File: tb/test_mon_hs_ctrl.sv
module test_mon_hs_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_tick = 1'b0;
  logic [7:0] host_tx_data = 8'h00;
  logic       host_tx_wr = 1'b0;
  logic       host_mx_act = 1'b0;
  logic       host_mr_act = 1'b0;
  logic       host_sts_rd = 1'b0;
  logic [7:0] line_rx_byte = 8'hFF;
  logic       line_mx_in = 1'b1;
  logic       line_mr_in = 1'b1;
  logic [7:0] line_tx_byte;
  logic       line_mx_out;
  logic       line_mr_out;
  logic       chan_active;
  logic [7:0] rx_byte;
  logic       prog_seq;
  logic       ev_ack, ev_end, ev_abort, ev_rx;
  logic [3:0] sts_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mon_hs_ctrl i_mon_hs_ctrl (
    .clk(clk), .rst_n(rst_n), .frm_tick(frm_tick),
    .host_tx_data(host_tx_data), .host_tx_wr(host_tx_wr),
    .host_mx_act(host_mx_act), .host_mr_act(host_mr_act),
    .host_sts_rd(host_sts_rd), .line_rx_byte(line_rx_byte),
    .line_mx_in(line_mx_in), .line_mr_in(line_mr_in),
    .line_tx_byte(line_tx_byte), .line_mx_out(line_mx_out),
    .line_mr_out(line_mr_out), .chan_active(chan_active),
    .rx_byte(rx_byte), .prog_seq(prog_seq), .ev_ack(ev_ack),
    .ev_end(ev_end), .ev_abort(ev_abort), .ev_rx(ev_rx),
    .sts_flags(sts_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // far-end levels describe the frame that the strobe closes
  task automatic frame(input logic f_mx, input logic f_mr, input logic [7:0] f_byte);
    line_mx_in = f_mx;
    line_mr_in = f_mr;
    line_rx_byte = f_byte;
    @(negedge clk) frm_tick = 1'b1;
    @(negedge clk) frm_tick = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] b);
    host_tx_data = b;
    @(negedge clk) host_tx_wr = 1'b1;
    @(negedge clk) host_tx_wr = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) host_sts_rd = 1'b1;
    @(negedge clk) host_sts_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mx_out", line_mx_out, 1);
    chk("R1 mr_out", line_mr_out, 1);
    chk("R1 tx_byte", line_tx_byte, 8'hFF);
    chk("R1 chan_active", chan_active, 0);
    chk("R1 prog/rx_byte", {prog_seq, rx_byte}, 0);
    chk("R1 pulses", {ev_ack, ev_end, ev_abort, ev_rx}, 0);
    chk("R1 sts_flags", sts_flags, 0);
  endtask

  task automatic t_send();
    host_write(8'hA1);
    host_mx_act = 1'b1;
    frame(1, 1, 8'hFF);
    chk("R2 mx_out active", line_mx_out, 0);
    chk("R2 tx byte A1", line_tx_byte, 8'hA1);
    chk("R3 active on start", chan_active, 1);
    chk("R5 no ack before MR", ev_ack, 0);
    frame(1, 0, 8'hFF);
    chk("R5 ack first byte", ev_ack, 1);
    frame(1, 0, 8'hFF);
    chk("R5 no repeat ack", ev_ack, 0);
    host_write(8'h55);
    host_mx_act = 1'b0;
    frame(1, 0, 8'hFF);
    chk("R2 mx_out marker", line_mx_out, 1);
    chk("R6 no abort at marker", ev_abort, 0);
    host_mx_act = 1'b1;
    frame(1, 0, 8'hFF);
    chk("R5 no ack in marker frame", ev_ack, 0);
    chk("R2 tx byte 55", line_tx_byte, 8'h55);
    frame(1, 1, 8'hFF);
    chk("R6 no abort on new byte", ev_abort, 0);
    frame(1, 0, 8'hFF);
    chk("R5 ack second byte", ev_ack, 1);
    host_mx_act = 1'b0;
    frame(1, 0, 8'hFF);
    frame(1, 1, 8'hFF);
    chk("R4 no end after one quiet frame", ev_end, 0);
    chk("R3 still active", chan_active, 1);
    chk("R6 no abort with MX released", ev_abort, 0);
    frame(1, 1, 8'hFF);
    chk("R4 end pulse", ev_end, 1);
    chk("R3 inactive after end", chan_active, 0);
    @(negedge clk);
    chk("R10 end pulse one cycle", ev_end, 0);
    chk("R9 sticky ack+end", sts_flags, 4'b0011);
    clear_flags();
    chk("R9 cleared by read", sts_flags, 4'b0000);
  endtask

  task automatic t_abort();
    host_write(8'h33);
    host_mx_act = 1'b1;
    frame(1, 1, 8'hFF);
    frame(1, 0, 8'hFF);
    chk("R5 ack before abort", ev_ack, 1);
    frame(1, 1, 8'hFF);
    chk("R6 abort pulse", ev_abort, 1);
    chk("R4 no end on abort", ev_end, 0);
    @(negedge clk);
    chk("R10 abort pulse one cycle", ev_abort, 0);
    chk("R9 abort sticky", sts_flags[2], 1);
    host_mx_act = 1'b0;
    frame(1, 1, 8'hFF);
    frame(1, 1, 8'hFF);
    frame(1, 1, 8'hFF);
    chk("R4 end after abort", ev_end, 1);
    clear_flags();
  endtask

  task automatic t_receive();
    frame(1, 1, 8'hFF);
    chk("R7 no capture when idle", ev_rx, 0);
    frame(0, 1, 8'h31);
    chk("R7 rx pulse", ev_rx, 1);
    chk("R7 rx byte 31", rx_byte, 8'h31);
    chk("R8 prog flag set", prog_seq, 1);
    chk("R3 active by far end", chan_active, 1);
    host_mr_act = 1'b1;
    frame(0, 1, 8'h77);
    chk("R2 mr_out active", line_mr_out, 0);
    chk("R7 no capture while MX held", {ev_rx, rx_byte}, {1'b0, 8'h31});
    frame(1, 1, 8'hFF);
    frame(0, 1, 8'h40);
    chk("R7 rx byte 40", rx_byte, 8'h40);
    chk("R8 prog flag kept", prog_seq, 1);
    host_mr_act = 1'b0;
    frame(1, 1, 8'hFF);
    frame(1, 1, 8'hFF);
    frame(1, 1, 8'hFF);
    chk("R4 rx message end", ev_end, 1);
    frame(0, 1, 8'h22);
    chk("R8 prog flag new message", prog_seq, 0);
    chk("R7 rx byte 22", rx_byte, 8'h22);
    @(negedge clk);
    chk("R9 rx sticky", sts_flags[3], 1);
    clear_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send();
    t_abort();
    t_receive();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule